// File: doc/BRIEF.md
# Four-Phase Latch Stage Controller

This block stands in for the global clock at one latch of a desynchronized pipeline. Each stage has two handshake ports. It takes requests from its predecessor on `req_in` and answers on `ack_in`. It offers items to its successor on `req_out` and waits for `ack_out`. It drives `latch_opaque`, which is 0 while the latch is transparent and 1 while it holds an item. An internal data register takes a new item at the moment the latch closes.

Both ports use the return-to-zero four-phase sequence: request high, acknowledge high, request low, acknowledge low. The block is modelled as a clocked state machine that samples the handshake wires, so it can be synthesized and simulated like ordinary logic. The `MODE` parameter selects how far the two ports may overlap:

- **Simple** is strictly sequential.
- **Semi-decoupled** lets the input return-to-zero phase run alongside the output request.
- **Fully decoupled** also lets the next item be taken while the successor's acknowledge is still high.

Stages are even or odd, like the two halves of a master-slave flip-flop. An odd stage leaves reset holding its initial value as a token and offers it at once. An even stage leaves reset empty and transparent. Chains and rings built from these stages deliver the same data sequence as the clocked pipeline they replace.

Top module: `latch_hs_ctrl`

## Requirements
- R1: With `ODD`=0, reset (synchronous, active high) leaves `ack_in`=0, `req_out`=0, `latch_opaque`=0 and `data_out`=`INIT`. These values hold while `req_in` stays low.
- R2: `latch_opaque` rises only on a clock edge at which `req_in` was sampled high.
- R3: On the edge where the latch closes, `ack_in` rises and `data_out` takes the sampled `data_in`. On a later edge, `req_out` rises once `ack_out` is sampled low, which is the very next edge if it is already low.
- R4: The latch never reopens for a new item before the successor has acknowledged the current one, and `latch_opaque` stays 1 while `req_out` is high.
- R5: `req_out` falls only after `ack_out` was sampled high and rises only while `ack_out` is sampled low. `ack_in` falls only after `req_in` was sampled low.
- R6: With `MODE`=HS_SIMPLE (0), `ack_in` and `latch_opaque` both stay high until `req_out` is low, `ack_out` is sampled low and `req_in` is sampled low. Both then fall on the same edge.
- R7: With `MODE`=HS_SEMI (1), `ack_in` falls on the edge after `req_in` is sampled low, whatever the output port is doing. The latch reopens on the edge where `ack_out` is seen with `req_out` high. A new capture waits for `ack_out` to be low.
- R8: With `MODE`=HS_FULL (2), a new item may be captured while `ack_out` is still high. Its `req_out` is held low until `ack_out` is sampled low.
- R9: A chain of even stages delivers the items in the order and with the values given at its input. `data_out` is stable for as long as `req_out` stays high.
- R10: A ring of three stages, stage 0 odd with an increment in the path from stage 2 back to stage 0, keeps circulating its token when every stage is semi- or fully decoupled. Each capture at stage 0 yields `INIT` plus the capture count. A ring of three simple stages stalls with no capture at stage 0.
- R11: With `ODD`=1, reset leaves `latch_opaque`=1 and `data_out`=`INIT`, and `req_out` rises on the first edge after reset if `ack_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 1 | Request from the predecessor stage |
| ack_in | output | 1 | Acknowledge to the predecessor stage |
| data_in | input | DW | Item presented by the predecessor |
| req_out | output | 1 | Request to the successor stage |
| ack_out | input | 1 | Acknowledge from the successor stage |
| data_out | output | DW | Item held by this latch |
| latch_opaque | output | 1 | Latch control: 0 transparent, 1 opaque |

## Verification
The case that matters most is an input capture landing in the same cycle as an output acknowledge that has not yet returned to zero. The fully decoupled stage must accept it. The semi-decoupled stage must defer it, and the simple stage must not even have reopened. The bench provokes this by driving three single stages with identical stimulus. It raises a new request while the successor acknowledge is held high, then reads on that edge and the next the latch state, `ack_in`, the captured value and whether `req_out` is withheld. Pipelines swept over source and sink delays, and three rings, then judge sequence preservation, liveness and the simple-ring stall.

// File: rtl/lhc_pkg.sv
package lhc_pkg;

    typedef enum logic [1:0] {
        HS_SIMPLE = 2'd0,
        HS_SEMI   = 2'd1,
        HS_FULL   = 2'd2
    } hs_mode_e;

    // input-side state: latch control and acknowledge to predecessor
    typedef struct packed {
        logic lt;
        logic ai;
    } in_st_t;

    // output-side state: request to successor and an item owed to it
    typedef struct packed {
        logic ro;
        logic pend;
    } out_st_t;

endpackage

// File: rtl/lhc_out_side.sv
module lhc_out_side
    import lhc_pkg::*;
#(
    parameter bit ODD = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic ack_out,
    output logic req_out,
    output logic busy,
    output logic deliver
);

    out_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pend = 1'b1;
        end
        if (st_q.pend && !st_q.ro && !ack_out) begin
            st_d.ro   = 1'b1;
            st_d.pend = 1'b0;
        end
        if (st_q.ro && ack_out) begin
            st_d.ro = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ro: 1'b0, pend: ODD};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_out = st_q.ro;
    assign busy    = st_q.ro | st_q.pend;
    assign deliver = st_q.ro & ack_out;

    AST_ROUT_FALL_ACKED: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.ro) |-> $past(ack_out)) else $error("req_out fell unacknowledged"); // R5
    AST_ROUT_RISE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.ro) |-> !$past(ack_out)) else $error("req_out rose over high ack"); // R5
    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy) else $error("capture while an item is still owed"); // R3

endmodule

// File: rtl/lhc_in_side.sv
module lhc_in_side
    import lhc_pkg::*;
#(
    parameter hs_mode_e MODE = HS_SEMI,
    parameter bit       ODD  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    input  logic ack_out,
    input  logic busy,
    input  logic deliver,
    output logic ack_in,
    output logic latch_opaque,
    output logic cap
);

    in_st_t st_q, st_d;
    logic   ack_ok;
    logic   open_now;
    logic   drop_ack;

    if (MODE == HS_SIMPLE) begin : g_simple
        assign ack_ok   = !ack_out;
        assign open_now = st_q.lt && !busy && !ack_out && (!st_q.ai || !req_in);
        assign drop_ack = open_now;

        AST_SIMPLE_OPEN_LATE: assert property (@(posedge clk) disable iff (rst)
            $fell(st_q.lt) |-> (!$past(ack_out) && !$past(busy))) else $error("simple reopened early"); // R6
        AST_SIMPLE_ACK_WITH_OPEN: assert property (@(posedge clk) disable iff (rst)
            $fell(st_q.ai) |-> $fell(st_q.lt)) else $error("simple ack_in fell alone"); // R6
    end else begin : g_decoupled
        if (MODE == HS_FULL) begin : g_full
            assign ack_ok = 1'b1;
        end else begin : g_semi
            assign ack_ok = !ack_out;

            AST_SEMI_WAIT_ACK: assert property (@(posedge clk) disable iff (rst)
                $rose(st_q.lt) |-> !$past(ack_out)) else $error("semi captured over high ack"); // R7
        end
        assign open_now = deliver;
        assign drop_ack = st_q.ai && !req_in;

        AST_OPEN_ON_ACK: assert property (@(posedge clk) disable iff (rst)
            $fell(st_q.lt) |-> $past(ack_out)) else $error("latch reopened unacknowledged"); // R4
        AST_DEC_ACK_RTZ: assert property (@(posedge clk) disable iff (rst)
            (st_q.ai && !req_in) |=> !st_q.ai) else $error("ack_in late to return"); // R7
    end

    assign cap = req_in && !st_q.ai && !st_q.lt && !busy && ack_ok;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.lt = 1'b1;
            st_d.ai = 1'b1;
        end
        if (open_now) begin
            st_d.lt = 1'b0;
        end
        if (drop_ack) begin
            st_d.ai = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{lt: ODD, ai: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_in       = st_q.ai;
    assign latch_opaque = st_q.lt;

    AST_CLOSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.lt) |-> $past(req_in)) else $error("latch closed without request"); // R2
    AST_ACKIN_WITH_CLOSE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.ai) |-> $rose(st_q.lt)) else $error("ack_in rose without capture"); // R3
    AST_ACKIN_RTZ_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.ai) |-> !$past(req_in)) else $error("ack_in fell over high request"); // R5

endmodule

// File: rtl/lhc_data_latch.sv
module lhc_data_latch #(
    parameter int            DW   = 8,
    parameter logic [DW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out
);

    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap) begin
            data_d = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= INIT;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_out = data_q;

endmodule

// File: rtl/latch_hs_ctrl.sv
module latch_hs_ctrl #(
    parameter lhc_pkg::hs_mode_e MODE = lhc_pkg::HS_SEMI,
    parameter bit                ODD  = 1'b0,
    parameter int                DW   = 8,
    parameter logic [DW-1:0]     INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_in,
    output logic          ack_in,
    input  logic [DW-1:0] data_in,
    output logic          req_out,
    input  logic          ack_out,
    output logic [DW-1:0] data_out,
    output logic          latch_opaque
);

    logic cap;
    logic busy;
    logic deliver;

    lhc_in_side #(
        .MODE (MODE),
        .ODD  (ODD)
    ) in_side_i (
        .clk          (clk),
        .rst          (rst),
        .req_in       (req_in),
        .ack_out      (ack_out),
        .busy         (busy),
        .deliver      (deliver),
        .ack_in       (ack_in),
        .latch_opaque (latch_opaque),
        .cap          (cap)
    );

    lhc_out_side #(
        .ODD (ODD)
    ) out_side_i (
        .clk     (clk),
        .rst     (rst),
        .load    (cap),
        .ack_out (ack_out),
        .req_out (req_out),
        .busy    (busy),
        .deliver (deliver)
    );

    lhc_data_latch #(
        .DW   (DW),
        .INIT (INIT)
    ) data_i (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .data_in  (data_in),
        .data_out (data_out)
    );

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_out && $past(req_out)) |-> $stable(data_out)) else $error("item changed while offered"); // R9
    AST_OPAQUE_WHILE_OFFER: assert property (@(posedge clk) disable iff (rst)
        req_out |-> latch_opaque) else $error("latch open while offering"); // R4

endmodule

// File: tb/latch_hs_ctrl_tb_top.sv
module latch_hs_ctrl_tb_top;
    import lhc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_ITEMS    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   bad    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- single stages, shared stimulus ----------------
    logic       req_a = 1'b0;
    logic       req_s = 1'b0;
    logic       ack_o = 1'b0;
    logic [7:0] din   = 8'h00;

    logic       m_ai, m_ro, m_op;  logic [7:0] m_d;   // semi, even
    logic       s_ai, s_ro, s_op;  logic [7:0] s_d;   // simple, even
    logic       f_ai, f_ro, f_op;  logic [7:0] f_d;   // full, even
    logic       o_ai, o_ro, o_op;  logic [7:0] o_d;   // semi, odd

    latch_hs_ctrl #(.MODE(HS_SEMI), .ODD(1'b0), .DW(8), .INIT(8'h00)) dut_i (
        .clk(clk), .rst(rst), .req_in(req_a), .ack_in(m_ai), .data_in(din),
        .req_out(m_ro), .ack_out(ack_o), .data_out(m_d), .latch_opaque(m_op));
    latch_hs_ctrl #(.MODE(HS_SIMPLE), .ODD(1'b0), .DW(8), .INIT(8'h00)) simp_i (
        .clk(clk), .rst(rst), .req_in(req_s), .ack_in(s_ai), .data_in(din),
        .req_out(s_ro), .ack_out(ack_o), .data_out(s_d), .latch_opaque(s_op));
    latch_hs_ctrl #(.MODE(HS_FULL), .ODD(1'b0), .DW(8), .INIT(8'h00)) full_i (
        .clk(clk), .rst(rst), .req_in(req_a), .ack_in(f_ai), .data_in(din),
        .req_out(f_ro), .ack_out(ack_o), .data_out(f_d), .latch_opaque(f_op));
    latch_hs_ctrl #(.MODE(HS_SEMI), .ODD(1'b1), .DW(8), .INIT(8'h5A)) odd_i (
        .clk(clk), .rst(rst), .req_in(req_a), .ack_in(o_ai), .data_in(din),
        .req_out(o_ro), .ack_out(ack_o), .data_out(o_d), .latch_opaque(o_op));

    // ---------------- three-stage pipelines, one per mode ----------------
    logic       p_req  [3];
    logic [7:0] p_din  [3];
    logic       p_ack  [3];
    logic       p_ackin[3];
    logic       p_rout [3];
    logic [7:0] p_dout [3];

    for (genvar m = 0; m < 3; m++) begin : g_pipe
        localparam hs_mode_e PM = (m == 0) ? HS_SIMPLE : ((m == 1) ? HS_SEMI : HS_FULL);
        logic       rq[4];
        logic       ak[4];
        logic [7:0] dd[4];
        logic       op[3];
        assign rq[0]      = p_req[m];
        assign dd[0]      = p_din[m];
        assign ak[3]      = p_ack[m];
        assign p_ackin[m] = ak[0];
        assign p_rout[m]  = rq[3];
        assign p_dout[m]  = dd[3];
        for (genvar k = 0; k < 3; k++) begin : g_st
            latch_hs_ctrl #(.MODE(PM), .ODD(1'b0), .DW(8), .INIT(8'h00)) st_i (
                .clk(clk), .rst(rst), .req_in(rq[k]), .ack_in(ak[k]), .data_in(dd[k]),
                .req_out(rq[k+1]), .ack_out(ak[k+1]), .data_out(dd[k+1]), .latch_opaque(op[k]));
        end
    end

    // ---------------- rings: semi, mixed semi/full, simple ----------------
    logic       rg_op0[3];
    logic [7:0] rg_d0 [3];

    for (genvar r = 0; r < 3; r++) begin : g_ring
        logic       rq[3];
        logic       ak[3];
        logic [7:0] dd[3];
        logic       op[3];
        for (genvar k = 0; k < 3; k++) begin : g_st
            localparam hs_mode_e SM = (r == 2) ? HS_SIMPLE :
                                      ((r == 1 && k != 0) ? HS_FULL : HS_SEMI);
            localparam logic [7:0] SI = (k == 0) ? 8'h40 : 8'h00;
            logic [7:0] sdin;
            if (k == 0) begin : g_inc
                assign sdin = dd[2] + 8'd1;
            end else begin : g_pass
                assign sdin = dd[(k + 2) % 3];
            end
            latch_hs_ctrl #(.MODE(SM), .ODD(k == 0), .DW(8), .INIT(SI)) st_i (
                .clk(clk), .rst(rst), .req_in(rq[(k + 2) % 3]), .ack_in(ak[k]), .data_in(sdin),
                .req_out(rq[k]), .ack_out(ak[(k + 1) % 3]), .data_out(dd[k]), .latch_opaque(op[k]));
        end
        assign rg_op0[r] = op[0];
        assign rg_d0[r]  = dd[0];
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] item(input int m, input int sd, input int kd, input int i);
        return 8'(i * 37 + m * 11 + sd * 5 + kd * 3 + 7);
    endfunction

    task automatic run_pipe(input int m, input int sd, input int kd);
        fork
            begin : src
                for (int i = 0; i < N_ITEMS; i++) begin
                    while (p_ackin[m] !== 1'b0) @(negedge clk);
                    tick(sd);
                    p_din[m] = item(m, sd, kd, i);
                    p_req[m] = 1'b1;
                    while (p_ackin[m] !== 1'b1) @(negedge clk);
                    p_req[m] = 1'b0;
                end
            end
            begin : snk
                for (int i = 0; i < N_ITEMS; i++) begin
                    while (p_rout[m] !== 1'b1) @(negedge clk);
                    chk($sformatf("R9 pipe mode%0d sd%0d kd%0d item%0d", m, sd, kd, i),
                        32'(p_dout[m]), 32'(item(m, sd, kd, i)));
                    tick(kd);
                    p_ack[m] = 1'b1;
                    while (p_rout[m] !== 1'b0) @(negedge clk);
                    tick(kd);
                    p_ack[m] = 1'b0;
                end
            end
        join
    endtask

    // ---------------- ring capture monitor (R10) ----------------
    int   ring_caps[3];
    logic ring_prev[3];

    always @(negedge clk) begin
        for (int r = 0; r < 3; r++) begin
            if (rst) begin
                ring_caps[r] = 0;
            end else if (rg_op0[r] && !ring_prev[r]) begin
                ring_caps[r] = ring_caps[r] + 1;
                chk($sformatf("R10 ring%0d capture %0d value", r, ring_caps[r]),
                    32'(rg_d0[r]), 32'(8'(8'h40 + ring_caps[r])));
            end
            ring_prev[r] = rg_op0[r];
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired, no handshake progress (R9 R10)");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        for (int m = 0; m < 3; m++) begin
            p_req[m] = 1'b0;
            p_ack[m] = 1'b0;
            p_din[m] = 8'h00;
        end
        tick(3);
        // reset state
        chk("R1 semi ack_in",  32'(m_ai), 0);
        chk("R1 semi req_out", 32'(m_ro), 0);
        chk("R1 semi opaque",  32'(m_op), 0);
        chk("R1 semi data",    32'(m_d),  0);
        chk("R1 simple opaque", 32'(s_op), 0);
        chk("R1 full opaque",   32'(f_op), 0);
        chk("R11 odd opaque",  32'(o_op), 1);
        chk("R11 odd data",    32'(o_d),  32'h5A);
        chk("R11 odd req_out in reset", 32'(o_ro), 0);
        rst = 1'b0;
        tick(1);
        chk("R11 odd req_out after reset", 32'(o_ro), 1);
        chk("R1 semi req_out idle", 32'(m_ro), 0);
        tick(3);
        chk("R2 semi stays open without request", 32'(m_op), 0);
        chk("R2 full stays open without request", 32'(f_op), 0);

        // first item
        din = 8'hA5; req_a = 1'b1; req_s = 1'b1;
        tick(1);
        chk("R3 semi close",   32'(m_op), 1);
        chk("R3 semi ack_in",  32'(m_ai), 1);
        chk("R3 semi data",    32'(m_d),  32'hA5);
        chk("R3 simple data",  32'(s_d),  32'hA5);
        chk("R3 full data",    32'(f_d),  32'hA5);
        chk("R3 semi req_out not yet", 32'(m_ro), 0);
        tick(1);
        chk("R3 semi req_out",   32'(m_ro), 1);
        chk("R3 simple req_out", 32'(s_ro), 1);
        chk("R3 full req_out",   32'(f_ro), 1);

        // predecessor returns to zero, successor silent
        din = 8'h3C; req_a = 1'b0; req_s = 1'b0;
        tick(1);
        chk("R7 semi ack_in rtz",     32'(m_ai), 0);
        chk("R7 full ack_in rtz",     32'(f_ai), 0);
        chk("R6 simple ack_in held",  32'(s_ai), 1);
        chk("R4 semi still opaque",   32'(m_op), 1);
        chk("R4 simple still opaque", 32'(s_op), 1);
        chk("R9 semi data kept",      32'(m_d),  32'hA5);

        // successor acknowledges
        ack_o = 1'b1;
        tick(1);
        chk("R5 semi req_out falls",  32'(m_ro), 0);
        chk("R5 simple req_out falls", 32'(s_ro), 0);
        chk("R7 semi reopens",        32'(m_op), 0);
        chk("R4 full reopens",        32'(f_op), 0);
        chk("R6 simple stays opaque", 32'(s_op), 1);
        chk("R6 simple ack_in held",  32'(s_ai), 1);
        chk("R11 odd token delivered", 32'(o_ro), 0);
        chk("R11 odd reopens",        32'(o_op), 0);

        // new request while successor ack still high
        req_a = 1'b1;
        tick(1);
        chk("R8 full captures early", 32'(f_op), 1);
        chk("R8 full ack_in",         32'(f_ai), 1);
        chk("R8 full data",           32'(f_d),  32'h3C);
        chk("R8 full req_out held",   32'(f_ro), 0);
        chk("R7 semi defers capture", 32'(m_op), 0);
        chk("R7 semi ack_in low",     32'(m_ai), 0);
        chk("R7 semi data old",       32'(m_d),  32'hA5);
        tick(1);
        chk("R8 full req_out still held", 32'(f_ro), 0);

        // successor returns to zero
        ack_o = 1'b0;
        tick(1);
        chk("R8 full req_out rises", 32'(f_ro), 1);
        chk("R7 semi captures",      32'(m_op), 1);
        chk("R7 semi data",          32'(m_d),  32'h3C);
        chk("R7 semi req_out next",  32'(m_ro), 0);
        chk("R6 simple reopens",     32'(s_op), 0);
        chk("R6 simple ack_in rtz",  32'(s_ai), 0);

        // pipeline sweep
        for (int m = 0; m < 3; m++)
            for (int sd = 0; sd < 3; sd++)
                for (int kd = 0; kd < 4; kd++)
                    run_pipe(m, sd, kd);

        // ring outcomes
        tick(2);
        chk("R10 semi ring live",  32'(ring_caps[0] >= 5), 1);
        chk("R10 mixed ring live", 32'(ring_caps[1] >= 5), 1);
        chk("R10 simple ring stalls", 32'(ring_caps[2]), 0);
        chk("R10 simple ring stage0 stuck opaque", 32'(rg_op0[2]), 1);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule